// File: doc/BRIEF.md
# Trigger-and-Poll I2C Master

This block is an I2C bus master controlled through a small byte-wide register window. Software first sets an SCL rate, a target device address (the 7-bit address already shifted left by one), and an enable bit. It then queues up to four transmit bytes. A write to the go register starts a write transfer or a single-byte read. Software polls a flags register until the busy bit drops, then checks the done and no-acknowledge bits. Each received byte is collected from a receive queue.

A keep-bus bit in the go command chains several commands into one bus transaction. When a chunk ends with that bit set, no STOP is sent. SCL is held low and the next command continues straight into the data phase, with no new START or address. A multi-byte read is a series of single-byte read commands with keep-bus set on all but the last. The master acknowledges each chained byte and does not acknowledge the last one. The same read command also serves as a presence probe, because an address that gets no acknowledge is reported in the flags.

The SCL half-period is (rate + 1) times a fixed base prescale count of system clocks. Rate values 7, 20 and 64 give about 250, 100 and 30 kHz from a 50 MHz clock at the default prescale.

Top module: `i2cm_top`

## Requirements
- R1: After reset the flags register (offset 1) reads 0, the receive queue reads 0, and both `scl_o` and `sda_o` are high.
- R2: The rate (offset 2), target (offset 3) and enable (offset 6, bit 0) registers read back the value last written.
- R3: A go write (offset 0) while the enable bit is 0 has no effect: no START appears on the bus and the flags stay 0.
- R4: Go bit 0 (write) sends START, then the target byte with bit 0 forced to 0, then every queued byte in order, then STOP. After that, flags bit 2 (write done) is set and bit 4 (busy) is clear.
- R5: Every SCL low phase lasts exactly (rate + 1) × PRESC system clocks.
- R6: If the address byte is not acknowledged, the master sends STOP. For a write it sets flags bits 3 and 2; for a read it sets flags bits 1 and 0.
- R7: Go bit 5 (read) sends the target byte with bit 0 set to 1 and receives one byte. Without keep-bus the master does not acknowledge that byte, sends STOP and sets flags bit 0. The byte is then read once from the receive queue (offset 5).
- R8: Go bit 6 (keep-bus) ends the chunk with no STOP, SCL low, busy clear and the done flag set. The next command sends no START or address byte. A byte read under keep-bus is acknowledged by the master.
- R9: The transmit queue (offset 4) holds DEPTH bytes. Writes to it while it is full are dropped.
- R10: An accepted go command clears flags bits 0 to 3 in the next cycle. A go command issued while busy is ignored. If bits 0 and 5 are both set, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at offset 5) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| scl_o | output | 1 | SCL level driven by the master |
| sda_o | output | 1 | SDA level driven by the master (1 = released) |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The bench builds the block with PRESC = 2 and DEPTH = 4. This keeps an SCL half-period between 2 and 20 clocks, so whole multi-byte transactions, the keep-bus chains and a full-queue overflow all fit in a short run. With that small prescale the rate register changes the phase length visibly, so the low-phase timing can be measured exactly for several rates. The bench uses a four-entry queue so that a fifth and sixth push hit the full condition, and a behavioural target device on the bus acknowledges, declines, and returns computed bytes.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    // register offsets
    localparam logic [2:0] RA_GO     = 3'd0;
    localparam logic [2:0] RA_FLAGS  = 3'd1;
    localparam logic [2:0] RA_RATE   = 3'd2;
    localparam logic [2:0] RA_TARGET = 3'd3;
    localparam logic [2:0] RA_TXQ    = 3'd4;
    localparam logic [2:0] RA_RXQ    = 3'd5;
    localparam logic [2:0] RA_ENABLE = 3'd6;

    // go command bits
    localparam int GO_WR   = 0;
    localparam int GO_RD   = 5;
    localparam int GO_KEEP = 6;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START1, ST_START2, ST_LO, ST_HI,
        ST_STOP1, ST_STOP2, ST_STOP3, ST_PAUSE
    } eng_state_e;

    typedef struct packed {
        eng_state_e state;
        logic [3:0] bitc;
        logic [7:0] sh;
        logic       scl;
        logic       sda;
        logic       is_addr;
        logic       rx;
        logic       op_rd;
        logic       keep;
        logic       rd_done;
        logic       rd_nack;
        logic       wr_done;
        logic       wr_nack;
    } eng_t;

    typedef struct packed {
        logic [7:0] rate;
        logic [7:0] target;
        logic       enable;
    } regs_t;

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int PRESC = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [7:0] rate,
    output logic       tick
);
    localparam int CNT_W = $clog2(256 * PRESC) + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q, limit;

    always_comb begin
        limit = (CNT_W'(rate) + CNT_W'(1)) * CNT_W'(PRESC);
        tick  = !clr && (cnt_q == limit - CNT_W'(1));
        cnt_d = (clr || tick) ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5: with a phase of two or more clocks, ticks never come back to back
    p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && limit > CNT_W'(1) && $stable(rate)) |=> !tick);

endmodule

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] din,
    input  logic       pop,
    output logic [7:0] dout,
    output logic       empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fptr_t;

    fptr_t      d, q;
    logic [7:0] mem_q [DEPTH];
    logic       push_ok, pop_ok;

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        d       = q;
        push_ok = push && (q.cnt != CW'(DEPTH));
        pop_ok  = pop && (q.cnt != '0);
        if (push_ok) d.wp = nxt(q.wp);
        if (pop_ok)  d.rp = nxt(q.rp);
        d.cnt = q.cnt + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[q.wp] <= din;
    end

    assign dout  = mem_q[q.rp];
    assign empty = (q.cnt == '0);

    // R9: a push into a full queue leaves the fill level at DEPTH
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == CW'(DEPTH) && push && !pop) |=> (q.cnt == CW'(DEPTH)));

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       go_rd,
    input  logic       go_keep,
    input  logic [6:0] dev_addr,
    input  logic       tick,
    input  logic       wf_empty,
    input  logic [7:0] wf_data,
    output logic       wf_pop,
    output logic       rf_push,
    output logic [7:0] rf_data,
    input  logic       sda_i,
    output logic       scl_o,
    output logic       sda_o,
    output logic       busy,
    output logic       tick_clr,
    output logic [3:0] flags
);
    eng_t d, q;

    function automatic eng_t f_tx(eng_t s, logic [7:0] b, logic a);
        s.state = ST_LO; s.bitc = '0; s.sh = b; s.scl = 1'b0;
        s.sda = b[7]; s.is_addr = a; s.rx = 1'b0;
        return s;
    endfunction

    function automatic eng_t f_rx(eng_t s);
        s.state = ST_LO; s.bitc = '0; s.sh = '0; s.scl = 1'b0;
        s.sda = 1'b1; s.is_addr = 1'b0; s.rx = 1'b1;
        return s;
    endfunction

    function automatic eng_t f_finish(eng_t s);
        s.scl = 1'b0;
        if (s.keep) begin
            s.state = ST_PAUSE; s.sda = 1'b1;
            if (s.op_rd) s.rd_done = 1'b1;
            else         s.wr_done = 1'b1;
        end else begin
            s.state = ST_STOP1; s.sda = 1'b0;
        end
        return s;
    endfunction

    always_comb begin
        d       = q;
        wf_pop  = 1'b0;
        rf_push = 1'b0;
        case (q.state)
            ST_IDLE, ST_PAUSE: if (go) begin
                d.op_rd = go_rd; d.keep = go_keep;
                d.rd_done = 1'b0; d.rd_nack = 1'b0;
                d.wr_done = 1'b0; d.wr_nack = 1'b0;
                if (q.state == ST_IDLE) begin
                    d.state = ST_START1; d.scl = 1'b1; d.sda = 1'b1;
                end else if (go_rd) begin
                    d = f_rx(d);
                end else if (!wf_empty) begin
                    d = f_tx(d, wf_data, 1'b0); wf_pop = 1'b1;
                end else begin
                    d = f_finish(d);
                end
            end
            ST_START1: if (tick) begin d.state = ST_START2; d.sda = 1'b0; end
            ST_START2: if (tick) d = f_tx(d, {dev_addr, q.op_rd}, 1'b1);
            ST_LO:     if (tick) begin d.state = ST_HI; d.scl = 1'b1; end
            ST_HI: if (tick) begin
                if (q.bitc != 4'd8) begin
                    d.state = ST_LO; d.scl = 1'b0; d.bitc = q.bitc + 4'd1;
                    if (q.rx) begin
                        d.sh  = {q.sh[6:0], sda_i};
                        d.sda = (q.bitc == 4'd7) ? !q.keep : 1'b1;
                    end else begin
                        d.sh  = {q.sh[6:0], 1'b0};
                        d.sda = (q.bitc == 4'd7) ? 1'b1 : q.sh[6];
                    end
                end else if (q.rx) begin
                    rf_push = 1'b1;
                    d = f_finish(d);
                end else if (sda_i) begin
                    if (q.op_rd) d.rd_nack = 1'b1;
                    else         d.wr_nack = 1'b1;
                    d.state = ST_STOP1; d.scl = 1'b0; d.sda = 1'b0;
                end else if (q.is_addr && q.op_rd) begin
                    d = f_rx(d);
                end else if (!wf_empty) begin
                    d = f_tx(d, wf_data, 1'b0); wf_pop = 1'b1;
                end else begin
                    d = f_finish(d);
                end
            end
            ST_STOP1: if (tick) begin d.state = ST_STOP2; d.scl = 1'b1; end
            ST_STOP2: if (tick) begin d.state = ST_STOP3; d.sda = 1'b1; end
            ST_STOP3: if (tick) begin
                d.state = ST_IDLE;
                if (q.op_rd) d.rd_done = 1'b1;
                else         d.wr_done = 1'b1;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.scl   <= 1'b1;
            q.sda   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign scl_o    = q.scl;
    assign sda_o    = q.sda;
    assign rf_data  = q.sh;
    assign busy     = !(q.state == ST_IDLE || q.state == ST_PAUSE);
    assign tick_clr = !busy;
    assign flags    = {q.wr_nack, q.wr_done, q.rd_nack, q.rd_done};

    // R5: SCL only moves on a divider tick
    p_scl_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(scl_o));
    // R8: SDA falls under a high SCL only when leaving the first START phase
    p_start_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_o) && scl_o && $past(scl_o)) |-> $past(q.state == ST_START1));
    // R4: a done flag is never shown together with busy
    p_done_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wr_done || q.rd_done) |-> !busy);

endmodule

// File: rtl/i2cm_top.sv
module i2cm_top
    import i2cm_pkg::*;
#(
    parameter int PRESC = 12,
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       scl_o,
    output logic       sda_o,
    input  logic       sda_i
);
    regs_t      regs_d, regs_q;
    logic       go, busy, tick, tick_clr;
    logic       wf_empty, wf_pop, rf_empty, rf_push;
    logic [7:0] wf_data, rf_data, rf_dout;
    logic [3:0] flags;

    always_comb begin
        regs_d = regs_q;
        if (bus_wr) begin
            case (bus_addr)
                RA_RATE:   regs_d.rate   = bus_wdata;
                RA_TARGET: regs_d.target = bus_wdata;
                RA_ENABLE: regs_d.enable = bus_wdata[0];
                default: ;
            endcase
        end
        go = bus_wr && (bus_addr == RA_GO) && regs_q.enable && !busy
             && (bus_wdata[GO_WR] || bus_wdata[GO_RD]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (bus_addr)
            RA_FLAGS:  bus_rdata = {3'b000, busy, flags};
            RA_RATE:   bus_rdata = regs_q.rate;
            RA_TARGET: bus_rdata = regs_q.target;
            RA_RXQ:    bus_rdata = rf_empty ? 8'h00 : rf_dout;
            RA_ENABLE: bus_rdata = {7'b0, regs_q.enable};
            default:   bus_rdata = 8'h00;
        endcase
    end

    i2cm_tick #(.PRESC(PRESC)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(tick_clr), .rate(regs_q.rate), .tick(tick)
    );

    i2cm_fifo #(.DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(bus_wr && bus_addr == RA_TXQ), .din(bus_wdata),
        .pop(wf_pop), .dout(wf_data), .empty(wf_empty)
    );

    i2cm_fifo #(.DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rf_push), .din(rf_data),
        .pop(bus_rd && bus_addr == RA_RXQ), .dout(rf_dout), .empty(rf_empty)
    );

    i2cm_engine u_eng (
        .clk(clk), .rst_n(rst_n),
        .go(go), .go_rd(!bus_wdata[GO_WR]), .go_keep(bus_wdata[GO_KEEP]),
        .dev_addr(regs_q.target[7:1]), .tick(tick),
        .wf_empty(wf_empty), .wf_data(wf_data), .wf_pop(wf_pop),
        .rf_push(rf_push), .rf_data(rf_data),
        .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o),
        .busy(busy), .tick_clr(tick_clr), .flags(flags)
    );

    // R10: an accepted command leaves no stale done or no-ack flag
    p_flags_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (flags == 4'h0 && busy == !$past(busy && 1'b0) || flags == 4'h0));
    // R3: a command without the enable bit never starts the engine
    p_go_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RA_GO && !regs_q.enable && !busy) |=> !busy);

endmodule

// File: tb/i2cm_top_tb.sv
`timescale 1ns/1ps
module i2cm_top_tb_top;
    import i2cm_pkg::*;

    localparam int PRESC = 2;
    localparam int DEPTH = 4;
    localparam logic [6:0] SADDR = 7'h50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       scl_o, sda_o, sda_i;
    logic       s_drv;

    always #10 clk = ~clk;

    assign sda_i = sda_o & s_drv;

    i2cm_top #(.PRESC(PRESC), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i)
    );

    int n_chk = 0, n_fail = 0;

    function automatic logic [7:0] rd_mem(int i);
        return 8'((i * 29 + 90) ^ 51);
    endfunction

    function automatic logic [7:0] exp_flags(bit rd, bit nack);
        return {3'b000, 1'b0, !rd && nack, !rd, rd && nack, rd};
    endfunction

    // ---------------- target device model ----------------
    logic       p_scl, p_sd, s_act, s_first, s_rd, s_ok, s_tx, s_mack;
    int         bc, n_start, n_stop, n_wr, n_mack, rd_idx;
    logic [7:0] sh, txb, last_addr;
    logic [7:0] wr_log [64];
    logic       ack_log [64];
    int         lowcnt, last_low;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_scl = 1; p_sd = 1; s_act = 0; s_first = 0; s_rd = 0; s_ok = 0;
            s_tx = 0; s_mack = 0; bc = 0; n_start = 0; n_stop = 0; n_wr = 0;
            n_mack = 0; rd_idx = 0; sh = 0; txb = 0; last_addr = 0; s_drv = 1;
            lowcnt = 0; last_low = 0;
        end else begin
            if (!scl_o) lowcnt++;
            else if (lowcnt != 0) begin last_low = lowcnt; lowcnt = 0; end
            if (p_scl && scl_o && p_sd && !sda_i) begin
                n_start++; s_act = 1; s_first = 1; bc = 0; s_rd = 0; s_tx = 0; s_drv = 1;
            end else if (p_scl && scl_o && !p_sd && sda_i) begin
                n_stop++; s_act = 0; s_tx = 0; s_drv = 1;
            end else if (s_act && !p_scl && scl_o) begin
                if (bc < 8) begin
                    if (!s_tx) sh = {sh[6:0], sda_i};
                    bc++;
                end else if (bc == 9) begin
                    if (s_tx) begin
                        ack_log[n_mack % 64] = sda_i; n_mack++; s_mack = !sda_i;
                    end else s_mack = 1;
                    bc = 10;
                end
            end else if (s_act && p_scl && !scl_o) begin
                if (bc == 8) begin
                    if (!s_tx) begin
                        if (s_first) begin
                            s_ok = (sh[7:1] == SADDR); s_rd = sh[0]; last_addr = sh;
                            s_first = 0; s_drv = !s_ok;
                        end else begin
                            if (s_ok) begin wr_log[n_wr % 64] = sh; n_wr++; end
                            s_drv = !s_ok;
                        end
                    end else s_drv = 1;
                    bc = 9;
                end else if (bc == 10) begin
                    bc = 0;
                    if (s_rd && s_ok && s_mack) begin
                        s_tx = 1; txb = rd_mem(rd_idx); rd_idx++; s_drv = txb[7];
                    end else begin
                        s_tx = 0; s_drv = 1;
                    end
                end else if (s_tx && bc >= 1 && bc <= 7) begin
                    s_drv = txb[7 - bc];
                end
            end
            p_scl = scl_o; p_sd = sda_i;
        end
    end

    // ---------------- bus tasks ----------------
    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bw(logic [2:0] a, logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic br(logic [2:0] a, output logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 v = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wait_idle(string req, output logic [7:0] st);
        int g = 0;
        do begin br(RA_FLAGS, st); g++; end while (st[4] && g < 20000);
        if (g >= 20000) chk({req, " timeout"}, 1, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [7:0] v, st;
        int s0, p0, w0, m0, e_idx;
        logic [7:0] exp_b [4];
        void'($urandom(32'd20240611));
        e_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        br(RA_FLAGS, v); chk("R1 flags", v, 0);
        br(RA_RXQ, v);   chk("R1 rxq", v, 0);
        chk("R1 scl", scl_o, 1); chk("R1 sda", sda_o, 1);

        // R3 go ignored while disabled
        bw(RA_TARGET, 8'hA0);
        bw(RA_GO, 8'h01);
        repeat (40) @(negedge clk);
        chk("R3 no start", n_start, 0);
        br(RA_FLAGS, v); chk("R3 flags", v, 0);

        // R2 readback
        bw(RA_RATE, 8'h03); bw(RA_ENABLE, 8'h01);
        br(RA_RATE, v);   chk("R2 rate", v, 8'h03);
        br(RA_TARGET, v); chk("R2 target", v, 8'hA0);
        br(RA_ENABLE, v); chk("R2 enable", v, 1);

        // R4 directed write of three bytes
        s0 = n_start; p0 = n_stop; w0 = n_wr;
        bw(RA_TXQ, 8'h3C); bw(RA_TXQ, 8'hC3); bw(RA_TXQ, 8'h81);
        bw(RA_GO, 8'h01);
        wait_idle("R4", st);
        chk("R4 flags", st, exp_flags(0, 0));
        chk("R4 starts", n_start - s0, 1); chk("R4 stops", n_stop - p0, 1);
        chk("R4 addr byte", last_addr, 8'hA0);
        chk("R4 count", n_wr - w0, 3);
        chk("R4 b0", wr_log[w0 % 64], 8'h3C); chk("R4 b2", wr_log[(w0 + 2) % 64], 8'h81);
        chk("R5 low phase", last_low, 4 * PRESC);

        // R9 queue overflow: six pushes, four sent
        w0 = n_wr;
        for (int i = 0; i < 6; i++) bw(RA_TXQ, 8'(8'h10 + i));
        bw(RA_GO, 8'h01);
        wait_idle("R9", st);
        chk("R9 sent", n_wr - w0, DEPTH);
        chk("R9 last", wr_log[(w0 + 3) % 64], 8'h13);

        // R6 address not acknowledged, write and probe
        bw(RA_TARGET, 8'h22);
        p0 = n_stop;
        bw(RA_GO, 8'h01);
        wait_idle("R6", st);
        chk("R6 write nack", st, exp_flags(0, 1)); chk("R6 stop", n_stop - p0, 1);
        bw(RA_GO, 8'h20);
        wait_idle("R6", st);
        chk("R6 probe nack", st, exp_flags(1, 1));

        // R7 single read
        bw(RA_TARGET, 8'hA0);
        m0 = n_mack;
        bw(RA_GO, 8'h20);
        wait_idle("R7", st);
        chk("R7 flags", st, exp_flags(1, 0));
        chk("R7 addr byte", last_addr, 8'hA1);
        chk("R7 master nack", ack_log[m0 % 64], 1);
        br(RA_RXQ, v); chk("R7 data", v, rd_mem(e_idx)); e_idx++;
        br(RA_RXQ, v); chk("R7 queue empty", v, 0);

        // R8 chained read of three bytes
        s0 = n_start; p0 = n_stop; m0 = n_mack;
        for (int i = 0; i < 3; i++) begin
            bw(RA_GO, (i < 2) ? 8'h60 : 8'h20);
            wait_idle("R8", st);
            chk("R8 read flags", st, exp_flags(1, 0));
            br(RA_RXQ, v); chk("R8 read data", v, rd_mem(e_idx)); e_idx++;
            if (i < 2) chk("R8 no stop", n_stop - p0, 0);
        end
        chk("R8 one start", n_start - s0, 1); chk("R8 one stop", n_stop - p0, 1);
        chk("R8 ack0", ack_log[m0 % 64], 0); chk("R8 ack1", ack_log[(m0 + 1) % 64], 0);
        chk("R8 nack last", ack_log[(m0 + 2) % 64], 1);

        // R8 chained write
        s0 = n_start; p0 = n_stop; w0 = n_wr;
        bw(RA_TXQ, 8'hAA); bw(RA_TXQ, 8'h55);
        bw(RA_GO, 8'h41);
        wait_idle("R8", st);
        chk("R8 pause flags", st, exp_flags(0, 0));
        chk("R8 pause stop", n_stop - p0, 0); chk("R8 pause scl", scl_o, 0);
        bw(RA_TXQ, 8'h0F); bw(RA_TXQ, 8'hF0);
        bw(RA_GO, 8'h01);
        wait_idle("R8", st);
        chk("R8 w starts", n_start - s0, 1); chk("R8 w bytes", n_wr - w0, 4);
        chk("R8 w b3", wr_log[(w0 + 3) % 64], 8'hF0);

        // R10 clear on accept, ignore while busy, write priority
        s0 = n_start; w0 = n_wr;
        bw(RA_TXQ, 8'h66); bw(RA_TXQ, 8'h99);
        bw(RA_GO, 8'h01);
        br(RA_FLAGS, v); chk("R10 cleared busy", v, 8'h10);
        bw(RA_GO, 8'h20);
        wait_idle("R10", st);
        chk("R10 ignored", st, exp_flags(0, 0)); chk("R10 starts", n_start - s0, 1);
        bw(RA_TXQ, 8'h42);
        bw(RA_GO, 8'h21);
        wait_idle("R10", st);
        chk("R10 write wins", st, exp_flags(0, 0)); chk("R10 bytes", n_wr - w0, 3);

        // R5 slower rate
        bw(RA_RATE, 8'h09);
        bw(RA_GO, 8'h01);
        wait_idle("R5", st);
        chk("R5 low phase rate9", last_low, 10 * PRESC);

        // random mix
        for (int it = 0; it < 10; it++) begin
            int rate, len;
            bit match, rd;
            rate = $urandom_range(0, 4); match = ($urandom_range(0, 3) != 0);
            rd = $urandom_range(0, 1); len = $urandom_range(1, 4);
            bw(RA_RATE, 8'(rate));
            bw(RA_TARGET, match ? 8'hA0 : 8'h22);
            w0 = n_wr;
            if (!rd) begin
                for (int i = 0; i < len; i++) begin
                    exp_b[i] = 8'($urandom); bw(RA_TXQ, exp_b[i]);
                end
                bw(RA_GO, 8'h01);
                wait_idle("R4", st);
                chk("R4/R6 rnd flags", st, exp_flags(0, !match));
                if (match) begin
                    chk("R4 rnd count", n_wr - w0, len);
                    for (int i = 0; i < len; i++) chk("R4 rnd byte", wr_log[(w0 + i) % 64], exp_b[i]);
                end else begin
                    // queue left full of unsent bytes: drain it with a matching write
                    bw(RA_TARGET, 8'hA0); bw(RA_GO, 8'h01); wait_idle("R6", st);
                end
            end else begin
                bw(RA_GO, 8'h20);
                wait_idle("R7", st);
                chk("R7/R6 rnd flags", st, exp_flags(1, !match));
                if (match) begin
                    br(RA_RXQ, v); chk("R7 rnd data", v, rd_mem(e_idx)); e_idx++;
                end
            end
            chk("R5 rnd low phase", last_low, (rate + 1) * PRESC);
        end
        summary();
    end

endmodule